// File: doc/BRIEF.md
# DMA Channel Start-Request Controller

This block is the trigger and sequencing front end of a four-channel DMA controller. Each channel holds an enable, a hardware-trigger selector and a down-counting transfer counter. A channel is started either by a software start strobe written through the configuration port, or by a rising edge on the peripheral interrupt line its selector names. Accepted requests are latched as pending. A fixed-priority arbiter hands them, one at a time, to an abstract transfer engine through a start/done handshake.

Each accepted request produces exactly one transfer cycle. A request that arrives while its channel already has one pending, or has a cycle in flight, is dropped without trace. Every completed cycle decrements the channel counter, and software reads the counter back to confirm that the previous cycle has finished. When the cycle that runs with the counter at zero completes, the channel disables itself, sets a sticky terminal-count flag and pulses its completion interrupt.

Top module: `dma_start_ctrl`

## Requirements
- R1: After synchronous reset every enable, selector, flag, counter and pending latch reads zero, and `xfer_start`, `xfer_ch` and `tc_irq` are zero.
- R2: A control write (`cfg_sel`=0) with bit 0 (enable) and bit 1 (start strobe) both set latches a request on the next edge, and `xfer_start` pulses for one cycle one edge later. The start bit always reads back as 0.
- R3: With bits 6:4 of the control word (selector) equal to k in 1..7 and the channel enabled, a rising edge of `periph_irq[k-1]` latches a request with the same latency as R2. A line held high gives one request, and selector 0 disables the hardware trigger.
- R4: A software start and a hardware trigger for the same channel in the same clock produce a single request and a single transfer cycle.
- R5: A request for a channel that already has a pending request or an active cycle is discarded.
- R6: Among pending channels the lowest-numbered one is granted first, and `xfer_ch` carries the granted channel number while `xfer_start` is high.
- R7: At most one cycle is outstanding, so no new `xfer_start` is issued until the engine's `xfer_done` for the active cycle.
- R8: A count write (`cfg_sel`=1) loads the counter. Each `xfer_done` for a cycle of the channel decrements it by one while it is nonzero, and `rd_data` with `rd_sel`=1 returns it.
- R9: A done for a cycle that ran with the counter at zero clears the enable, sets the terminal-count flag (control readback bit 3) and pulses `tc_irq[ch]` for one cycle.
- R10: A control write with the enable bit set clears the terminal-count flag. A start strobe written with enable 0 issues nothing.
- R11: `xfer_done` while no cycle is active changes nothing.
- R12: Control readback carries enable at bit 0, flag at bit 3, selector at bits 6:4, pending at bit 8 and active at bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 1 | 0 = control word, 1 = counter |
| cfg_wdata | input | 16 | Write data |
| rd_ch | input | 2 | Channel addressed by the readback |
| rd_sel | input | 1 | 0 = control status, 1 = counter |
| rd_data | output | 16 | Readback data |
| periph_irq | input | 7 | Peripheral interrupt request lines |
| xfer_start | output | 1 | One-cycle start of a transfer cycle |
| xfer_ch | output | 2 | Channel of the issued cycle |
| xfer_done | input | 1 | Engine completion of the active cycle |
| tc_irq | output | 4 | Per-channel terminal-count pulse |

## Verification
A wrong pending or active bit shows up at the ports within two edges. Either `xfer_start` appears, or fails to appear, one edge after the grant should have happened, and control readback exposes both bits in the very next cycle. A counter that steps wrongly, or a terminal-count decision taken on the wrong value, shows on counter readback the cycle after the done and on `tc_irq` at the same point. The bench compares every output against a behavioural model on every clock, so any divergence is caught in the cycle it first becomes visible.

// File: rtl/dmasr_pkg.sv
package dmasr_pkg;

    localparam int DEF_NCH   = 4;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_NIRQ  = 7;
    localparam int DEF_DW    = 16;

    // control word bit positions (write and readback share them)
    localparam int B_EN     = 0;
    localparam int B_STG    = 1;
    localparam int B_TC     = 3;
    localparam int B_SEL_LO = 4;
    localparam int B_PEND   = 8;
    localparam int B_ACT    = 9;

    typedef enum logic {
        REG_CTRL  = 1'b0,
        REG_COUNT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic act;
        logic pend;
        logic tc;
        logic en;
    } ch_flags_t;

    function automatic logic [15:0] pack_status(input ch_flags_t f, input logic [2:0] sel);
        logic [15:0] w;
        w            = '0;
        w[B_EN]      = f.en;
        w[B_TC]      = f.tc;
        w[B_SEL_LO+:3] = sel;
        w[B_PEND]    = f.pend;
        w[B_ACT]     = f.act;
        return w;
    endfunction

endpackage

// File: rtl/dmasr_chan.sv
module dmasr_chan
    import dmasr_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int NIRQ  = DEF_NIRQ,
    parameter int DW    = DEF_DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctrl,
    input  logic            wr_cnt,
    input  logic [DW-1:0]   wdata,
    input  logic [NIRQ-1:0] irq_edge,
    input  logic            grant,
    input  logic            done,
    output logic            pend,
    output logic            act,
    output logic            tc_pulse,
    output logic [DW-1:0]   rd_ctrl,
    output logic [DW-1:0]   rd_cnt
);
    localparam int SEL_W = 3;
    localparam int SELN  = 1 << SEL_W;

    logic             en, tc;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
    logic [SELN-1:0]  edge_ext;
    logic             hw_hit, sw_hit, req;
    ch_flags_t        flags;

    always_comb begin
        edge_ext           = '0;
        edge_ext[NIRQ:1]   = irq_edge;
    end

    assign hw_hit = en && edge_ext[sel];
    assign sw_hit = wr_ctrl && wdata[B_STG] && wdata[B_EN];
    assign req    = hw_hit || sw_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            tc       <= 1'b0;
            sel      <= '0;
            cnt      <= '0;
            pend     <= 1'b0;
            act      <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= 1'b0;
            if (grant) begin
                pend <= 1'b0;
                act  <= 1'b1;
            end else if (req && !pend && !act) begin
                pend <= 1'b1;
            end
            if (wr_ctrl) begin
                en  <= wdata[B_EN];
                sel <= wdata[B_SEL_LO+:SEL_W];
                if (wdata[B_EN]) tc <= 1'b0;
            end
            if (wr_cnt) cnt <= wdata[CNT_W-1:0];
            if (done && act) begin
                act <= 1'b0;
                if (cnt == '0) begin
                    en       <= 1'b0;
                    tc       <= 1'b1;
                    tc_pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assign flags   = '{act: act, pend: pend, tc: tc, en: en};
    assign rd_ctrl = DW'(pack_status(flags, sel));
    assign rd_cnt  = DW'(cnt);

    AST_PEND_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !(pend && act)); // R5
    AST_TC_DISABLES: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> (!en && tc)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($fell(act) && !$past(wr_cnt) && $past(cnt) != '0) |-> cnt == $past(cnt) - 1'b1); // R8

endmodule

// File: rtl/dmasr_arb.sv
module dmasr_arb
    import dmasr_pkg::*;
#(
    parameter int NCH = DEF_NCH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         pend,
    input  logic                   busy,
    output logic [NCH-1:0]         grant,
    output logic                   start,
    output logic [$clog2(NCH)-1:0] start_ch
);
    localparam int CH_W = $clog2(NCH);

    logic [CH_W-1:0] win;

    always_comb begin
        grant = '0;
        win   = '0;
        if (!busy) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (pend[i]) begin
                    grant = '0;
                    grant[i] = 1'b1;
                    win   = CH_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start    <= 1'b0;
            start_ch <= '0;
        end else begin
            start <= |grant;
            if (|grant) start_ch <= win;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start |=> !start); // R7

    for (genvar g = 1; g < NCH; g++) begin : g_prio
        AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
            grant[g] |-> !(|pend[g-1:0])); // R6
    end

endmodule

// File: rtl/dma_start_ctrl.sv
module dma_start_ctrl
    import dmasr_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int CNT_W = DEF_CNT_W,
    parameter int NIRQ  = DEF_NIRQ,
    parameter int DW    = DEF_DW,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [CH_W-1:0] cfg_ch,
    input  logic            cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [CH_W-1:0] rd_ch,
    input  logic            rd_sel,
    output logic [DW-1:0]   rd_data,
    input  logic [NIRQ-1:0] periph_irq,
    output logic            xfer_start,
    output logic [CH_W-1:0] xfer_ch,
    input  logic            xfer_done,
    output logic [NCH-1:0]  tc_irq
);
    logic [NIRQ-1:0] irq_prev, irq_edge;
    logic [NCH-1:0]  pend_v, act_v, grant_v;
    logic [DW-1:0]   ctrl_rd [NCH];
    logic [DW-1:0]   cnt_rd  [NCH];
    logic            busy;

    always_ff @(posedge clk) begin
        if (rst) irq_prev <= '0;
        else     irq_prev <= periph_irq;
    end

    assign irq_edge = periph_irq & ~irq_prev;
    assign busy     = |act_v;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = cfg_we && (cfg_ch == CH_W'(c));
        dmasr_chan #(.CNT_W(CNT_W), .NIRQ(NIRQ), .DW(DW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (hit && (reg_sel_e'(cfg_sel) == REG_CTRL)),
            .wr_cnt   (hit && (reg_sel_e'(cfg_sel) == REG_COUNT)),
            .wdata    (cfg_wdata),
            .irq_edge (irq_edge),
            .grant    (grant_v[c]),
            .done     (xfer_done),
            .pend     (pend_v[c]),
            .act      (act_v[c]),
            .tc_pulse (tc_irq[c]),
            .rd_ctrl  (ctrl_rd[c]),
            .rd_cnt   (cnt_rd[c])
        );
    end

    dmasr_arb #(.NCH(NCH)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend_v),
        .busy     (busy),
        .grant    (grant_v),
        .start    (xfer_start),
        .start_ch (xfer_ch)
    );

    assign rd_data = rd_sel ? cnt_rd[rd_ch] : ctrl_rd[rd_ch];

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_v)); // R7
    AST_START_MATCHES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> act_v[xfer_ch]); // R6
    AST_IDLE_DONE_INERT: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !busy) |=> (tc_irq == '0)); // R11

endmodule

// File: tb/tb_dma_start_ctrl.sv
module tb_dma_start_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  rd_ch = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic [6:0]  periph_irq = '0;
    logic        xfer_start;
    logic [1:0]  xfer_ch;
    logic        xfer_done = 1'b0;
    logic [3:0]  tc_irq;

    always #4 clk = ~clk;

    dma_start_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .periph_irq(periph_irq), .xfer_start(xfer_start), .xfer_ch(xfer_ch),
        .xfer_done(xfer_done), .tc_irq(tc_irq)
    );

    int compared = 0;
    int mismatched = 0;
    string cur = "R1";
    bit armed = 0;

    // stimulus staged for the next cycle
    bit          s_rst = 1, s_we = 0, s_sel = 0, s_stray = 0;
    int          s_ch = 0;
    logic [15:0] s_wd = '0;
    logic [6:0]  s_irq = '0;
    int          eng_lat = 3, eng_cnt = 0, ncyc = 0;

    // reference model state
    int m_en[4], m_sel[4], m_tc[4], m_cnt[4], m_pend[4], m_act[4], m_tcirq[4];
    int m_prev = 0, m_start = 0, m_ch = 0;

    task automatic check(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur, what, act, exp, ncyc);
        end
    endtask

    function automatic int model_rd(int ch, int sel);
        if (sel != 0) return m_cnt[ch];
        return m_en[ch] | (m_tc[ch] << 3) | (m_sel[ch] << 4) | (m_pend[ch] << 8) | (m_act[ch] << 9);
    endfunction

    task automatic compare();
        int tcv = 0;
        for (int c = 0; c < 4; c++) tcv |= m_tcirq[c] << c;
        check("xfer_start", int'(xfer_start), m_start);
        check("xfer_ch", int'(xfer_ch), m_ch);
        check("tc_irq", int'(tc_irq), tcv);
        check("rd_data", int'(rd_data), model_rd(int'(rd_ch), int'(rd_sel)));
    endtask

    task automatic model_update();
        int edges, gnt, busy, irqv;
        int n_pend[4], n_act[4];
        if (rst) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_sel[c] = 0; m_tc[c] = 0; m_cnt[c] = 0;
                m_pend[c] = 0; m_act[c] = 0; m_tcirq[c] = 0;
            end
            m_prev = 0; m_start = 0; m_ch = 0;
            return;
        end
        irqv  = int'(periph_irq);
        edges = irqv & ~m_prev;
        busy  = 0;
        for (int c = 0; c < 4; c++) busy |= m_act[c];
        gnt = -1;
        if (busy == 0)
            for (int c = 3; c >= 0; c--) if (m_pend[c] != 0) gnt = c;
        for (int c = 0; c < 4; c++) begin
            bit wr, hw, sw;
            wr = cfg_we && int'(cfg_ch) == c;
            hw = m_en[c] != 0 && m_sel[c] != 0 && ((edges >> (m_sel[c] - 1)) & 1) != 0;
            sw = wr && !cfg_sel && cfg_wdata[1] && cfg_wdata[0];
            n_pend[c] = m_pend[c];
            n_act[c]  = m_act[c];
            if (gnt == c) begin n_pend[c] = 0; n_act[c] = 1; end
            else if ((hw || sw) && m_pend[c] == 0 && m_act[c] == 0) n_pend[c] = 1;
            m_tcirq[c] = 0;
            if (wr && !cfg_sel) begin
                m_en[c]  = int'(cfg_wdata[0]);
                m_sel[c] = int'(cfg_wdata[6:4]);
                if (cfg_wdata[0]) m_tc[c] = 0;
            end
            if (wr && cfg_sel) m_cnt[c] = int'(cfg_wdata);
            if (xfer_done && m_act[c] != 0) begin
                n_act[c] = 0;
                if (m_cnt[c] == 0) begin m_en[c] = 0; m_tc[c] = 1; m_tcirq[c] = 1; end
                else m_cnt[c] = m_cnt[c] - 1;
            end
        end
        for (int c = 0; c < 4; c++) begin m_pend[c] = n_pend[c]; m_act[c] = n_act[c]; end
        m_start = (gnt >= 0) ? 1 : 0;
        if (gnt >= 0) m_ch = gnt;
        m_prev = irqv;
    endtask

    task automatic tick();
        @(negedge clk);
        if (armed) compare();
        rst        = s_rst;
        cfg_we     = s_we;
        cfg_ch     = 2'(s_ch);
        cfg_sel    = s_sel;
        cfg_wdata  = s_wd;
        periph_irq = s_irq;
        rd_ch      = 2'(ncyc % 4);
        rd_sel     = ((ncyc / 4) % 2) != 0;
        xfer_done  = s_stray;
        if (xfer_start === 1'b1) eng_cnt = eng_lat;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) xfer_done = 1'b1;
        end
        @(posedge clk);
        model_update();
        armed   = 1;
        s_we    = 0;
        s_stray = 0;
        ncyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int ch, bit sel, logic [15:0] d);
        s_we = 1; s_ch = ch; s_sel = sel; s_wd = d;
        tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        cur = "R1";  idle(3); s_rst = 0; idle(8);
        // channel 0: counter 2, enable, software start
        cur = "R8";  wr(0, 1, 16'd2); wr(0, 0, 16'h0001);
        cur = "R2";  wr(0, 0, 16'h0003); idle(1);
        cur = "R5";  wr(0, 0, 16'h0003); idle(2); wr(0, 0, 16'h0003); idle(8);
        cur = "R8";  wr(0, 0, 16'h0003); idle(8);
        cur = "R9";  wr(0, 0, 16'h0003); idle(8);
        cur = "R10"; wr(0, 0, 16'h0002); idle(4); wr(0, 0, 16'h0001); idle(3);
        cur = "R11"; s_stray = 1; tick(); idle(3);
        // channel 1: hardware trigger on line 1 (selector 2)
        cur = "R3";  wr(1, 1, 16'd5); wr(1, 0, 16'h0021);
        s_irq[1] = 1'b1; idle(12); s_irq[1] = 1'b0; idle(2);
        s_irq[1] = 1'b1; idle(8); s_irq[1] = 1'b0; idle(2);
        // selector 0: no hardware trigger
        wr(3, 0, 16'h0001); s_irq = 7'h7f; idle(6); s_irq = '0; idle(2);
        // channel 2: line 0 plus software start in the same clock
        cur = "R4";  wr(2, 1, 16'd3); wr(2, 0, 16'h0011);
        s_irq[0] = 1'b1; wr(2, 0, 16'h0013); idle(10); s_irq[0] = 1'b0; idle(2);
        // contention: ch0 busy, then ch3 and ch1 pending together
        cur = "R6/R7"; eng_lat = 6;
        wr(0, 0, 16'h0003); idle(1);
        s_irq[1] = 1'b1; wr(3, 0, 16'h0003); idle(30); s_irq[1] = 1'b0;
        cur = "R12"; eng_lat = 1;
        wr(2, 0, 16'h0053); idle(6); wr(3, 1, 16'hbeef); idle(8);
        summary();
        $finish;
    end
endmodule